// File: doc/BRIEF.md
# Endpoint Packet FIFO Access Window

This block is the processor-facing side of the packet buffers in a USB-style function controller. Every endpoint owns one word-aligned data address inside a small register window. A store to that address appends bytes to the endpoint's transmit buffer. A load from the same address removes bytes from its receive buffer. Stores and loads may be 8, 16 or 32 bits wide. The block splits them into bytes, or builds them from bytes, in little-endian order. Internally each buffer is one byte wide.

Software fills a transmit packet and then pulses that endpoint's commit strobe. The strobe closes the packet and hands it to the protocol engine, which drains it one byte at a time. In the receive direction the engine pushes bytes and then marks the end of the packet, and software reads the packet out. The shared `max_pkt` setting selects the buffering mode for every endpoint. When two maximum-size packets fit in the per-endpoint storage, each side holds two packets. Otherwise each side holds one packet. The block records illegal access widths, overruns and underruns in sticky per-endpoint flags. A flush event empties both buffers of any endpoint except endpoint 0.

Top module: `epf_ep_window`

## Requirements
- R1: Endpoint n answers at byte address BASE + 4·n, which is 0x20 + 4·n by default, so endpoint 15 sits at 0x5C. A load from an address that is unaligned or outside the window returns zero, and a store to such an address changes nothing.
- R2: A store appends 1, 2 or 4 bytes for `cpu_size` 0, 1 or 2, taken from `cpu_wdata` lowest byte first. The engine drains bytes in the same order, and `eng_tx_len` reports the remaining length of the head packet.
- R3: Bytes pushed by the engine become readable only after `eng_rx_end`. A load returns them lowest byte first, in bit 7:0 upward, on `cpu_rdata` one cycle after the request.
- R4: When the open packet has fewer bytes left than the access width, a load returns only those bytes, with zeros above them, and the packet is released.
- R5: The first access of a packet fixes its width. One narrower access may end the packet. Any of the following sets the endpoint's sticky `err_width` bit and discards the access: a wider access, any access after a narrower one, or size code 3. A discarded store writes no data. A discarded load returns zero and removes nothing.
- R6: Double buffering applies when 2·`max_pkt` ≤ FIFO_BYTES, and single buffering otherwise. After a commit, `tx_busy` stays high while every transmit slot holds a packet. It falls when the engine drains a packet.
- R7: A store or commit while `tx_busy` is high is ignored. The store also sets `err_over`.
- R8: A store that would exceed FIFO_BYTES held bytes is dropped whole and sets `err_over`.
- R9: A load when no complete receive packet is held returns zero and sets `err_under`.
- R10: A `flush_ev` pulse on endpoints 1 and above empties both of that endpoint's buffers and clears `tx_busy`. On endpoint 0 the pulse has no effect.
- R11: After reset every buffer is empty, and all flags, `tx_busy` and `cpu_rdata` are zero.
- R12: `rx_full` is high while every receive slot holds a packet. While it is high, engine bytes and end marks for that endpoint are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wr | input | 1 | Store strobe |
| cpu_rd | input | 1 | Load strobe (wins over `cpu_wr`) |
| cpu_size | input | 2 | 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = illegal |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, registered |
| tx_commit | input | NUM_EP | Per-endpoint packet commit strobes |
| tx_busy | output | NUM_EP | No transmit slot free after a commit |
| max_pkt | input | MP_W | Maximum packet size, selects buffering mode |
| flush_ev | input | NUM_EP | Per-endpoint flush pulses |
| eng_tx_ep | input | log2(NUM_EP) | Endpoint selected by the engine for draining |
| eng_tx_pop | input | 1 | Remove one byte from the head packet |
| eng_tx_data | output | 8 | Next transmit byte of the selected endpoint |
| eng_tx_len | output | log2(FIFO_BYTES)+1 | Bytes left in the head packet |
| eng_tx_has | output | 1 | A committed packet is present |
| eng_rx_ep | input | log2(NUM_EP) | Endpoint selected by the engine for receive |
| eng_rx_push | input | 1 | Append `eng_rx_data` |
| eng_rx_data | input | 8 | Receive byte |
| eng_rx_end | input | 1 | Close the receive packet |
| rx_full | output | NUM_EP | No receive slot free |
| rx_has | output | NUM_EP | A complete receive packet is readable |
| err_width | output | NUM_EP | Sticky width-rule violation |
| err_over | output | NUM_EP | Sticky dropped store |
| err_under | output | NUM_EP | Sticky empty load |

## Verification
The bench walks the address decode across both edges of the window and across unaligned and out-of-range addresses. A broken decode would put data on the wrong endpoint or return stale data. It drives a word followed by a halfword, and a byte after a narrower byte. A design with the width rule wrong would keep the illegal byte or reject the legal short final access. It fills a packet to exactly the storage size and then stores once more. It commits into single-buffer and double-buffer configurations and stores while busy, to catch a busy flag that clears early or a store that sneaks into the next packet. It flushes endpoint 0 and a higher endpoint, and lands a second receive packet while the only slot is taken. A wrong design would either lose endpoint 0 data or let the dropped packet appear on a load.

// File: rtl/epf_pkg.sv
package epf_pkg;

   typedef enum logic [1:0] {
      ACC_B8  = 2'd0,
      ACC_B16 = 2'd1,
      ACC_B32 = 2'd2,
      ACC_BAD = 2'd3
   } acc_size_e;

   function automatic logic [2:0] lane_count(input logic [1:0] sz);
      case (acc_size_e'(sz))
         ACC_B8:  return 3'd1;
         ACC_B16: return 3'd2;
         ACC_B32: return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/epf_pktq.sv
module epf_pktq #(
   parameter int DEPTH    = 16,
   parameter int WR_LANES = 4,
   parameter int RD_LANES = 4,
   localparam int AW      = $clog2(DEPTH),
   localparam int CNT_W   = AW + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic [2:0]              wr_n,
   input  logic [8*WR_LANES-1:0]   wr_data,
   input  logic                    commit,
   input  logic [2:0]              rd_n,
   input  logic                    rd_go,
   output logic [8*RD_LANES-1:0]   rd_data,
   output logic [CNT_W-1:0]        used,
   output logic [1:0]              pkts,
   output logic [CNT_W-1:0]        head_len,
   output logic                    released
);

   if ((1 << AW) != DEPTH || DEPTH < 4) begin : g_bad_depth
      $error("epf_pktq: DEPTH must be a power of two of at least 4");
   end
   if (WR_LANES < 1 || WR_LANES > 4 || RD_LANES < 1 || RD_LANES > 4) begin : g_bad_lanes
      $error("epf_pktq: lane counts must lie in 1..4");
   end

   logic [7:0]       mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [CNT_W-1:0] used_q, open_q, len0, len1;
   logic [1:0]       pkts_q;

   logic             has;
   logic [2:0]       peek_n, take;
   logic [CNT_W-1:0] open_n, len0_a, len1_a;
   logic [1:0]       pkts_a;

   always_comb begin
      has    = (pkts_q != 2'd0);
      if (!has)
         peek_n = 3'd0;
      else if (CNT_W'(rd_n) <= len0)
         peek_n = rd_n;
      else
         peek_n = len0[2:0];
      take     = rd_go ? peek_n : 3'd0;
      released = rd_go && has && (len0 == CNT_W'(peek_n));
      open_n   = open_q + CNT_W'(wr_n);

      pkts_a = pkts_q - (released ? 2'd1 : 2'd0);
      len0_a = released ? len1 : (len0 - CNT_W'(take));
      len1_a = len1;
      if (commit) begin
         if (pkts_a == 2'd0)
            len0_a = open_n;
         else
            len1_a = open_n;
         pkts_a = pkts_a + 2'd1;
      end
   end

   for (genvar k = 0; k < RD_LANES; k++) begin : g_rd_lane
      assign rd_data[8*k +: 8] = (3'(k) < peek_n) ? mem[rptr + AW'(k)] : 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!clr) begin
         for (int k = 0; k < WR_LANES; k++) begin
            if (3'(k) < wr_n)
               mem[wptr + AW'(k)] <= wr_data[8*k +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wptr   <= '0;
         rptr   <= '0;
         used_q <= '0;
         open_q <= '0;
         len0   <= '0;
         len1   <= '0;
         pkts_q <= '0;
      end else begin
         wptr   <= wptr + AW'(wr_n);
         rptr   <= rptr + AW'(take);
         used_q <= used_q + CNT_W'(wr_n) - CNT_W'(take);
         open_q <= commit ? '0 : open_n;
         len0   <= len0_a;
         len1   <= len1_a;
         pkts_q <= pkts_a;
      end
   end

   assign used     = used_q;
   assign pkts     = pkts_q;
   assign head_len = has ? len0 : '0;

   // R8
   used_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      used_q <= CNT_W'(DEPTH));

   // R6
   queue_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !clr) |-> (pkts_q != 2'd2 || released));

endmodule

// File: rtl/epf_width_gate.sv
module epf_width_gate
   import epf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       go,
   input  logic [1:0] sz,
   output logic       ok
);

   logic       locked, closed;
   logic [1:0] lk;

   assign ok = (acc_size_e'(sz) != ACC_BAD) &&
               (!locked || (!closed && sz <= lk));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         locked <= 1'b0;
         closed <= 1'b0;
         lk     <= 2'd0;
      end else if (go) begin
         if (!locked) begin
            locked <= 1'b1;
            lk     <= sz;
         end else if (sz < lk) begin
            closed <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/epf_ep_slice.sv
module epf_ep_slice
   import epf_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter bit FLUSHABLE = 1'b1,
   localparam int CNT_W    = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbl,
   input  logic             cpu_wr,
   input  logic             cpu_rd,
   input  logic [1:0]       cpu_sz,
   input  logic [31:0]      cpu_wdata,
   output logic [31:0]      rd_data,
   input  logic             commit_req,
   input  logic             flush_ev,
   input  logic             tx_pop,
   output logic [7:0]       tx_byte,
   output logic [CNT_W-1:0] tx_len,
   output logic             tx_has,
   input  logic             rx_push,
   input  logic [7:0]       rx_byte,
   input  logic             rx_end,
   output logic             rx_full,
   output logic             rx_has,
   output logic             busy,
   output logic             err_w,
   output logic             err_o,
   output logic             err_u
);

   logic             flush_i;
   logic [2:0]       nb;
   logic [1:0]       slots;

   logic             tx_ok, rx_ok;
   logic [CNT_W-1:0] tx_used, rx_used, rx_len;
   logic [1:0]       tx_pkts, rx_pkts;
   logic             tx_rel, rx_rel;
   logic [31:0]      rx_rd_data;

   logic             drop_busy, drop_w, drop_sp, wr_ok, commit_ok;
   logic             under, rd_w, rd_ok, push_ok, end_ok;
   logic [2:0]       tx_after;

   assign flush_i = flush_ev && FLUSHABLE;
   assign nb      = lane_count(cpu_sz);
   assign slots   = dbl ? 2'd2 : 2'd1;

   always_comb begin
      drop_busy = cpu_wr && busy;
      drop_w    = cpu_wr && !busy && !tx_ok;
      drop_sp   = cpu_wr && !busy && tx_ok &&
                  (CNT_W'(nb) > (CNT_W'(DEPTH) - tx_used));
      wr_ok     = cpu_wr && !busy && tx_ok && !drop_sp;
      commit_ok = commit_req && !busy && !flush_i;
      tx_after  = {1'b0, tx_pkts} - {2'b0, tx_rel} + 3'd1;

      under   = cpu_rd && (rx_pkts == 2'd0);
      rd_w    = cpu_rd && (rx_pkts != 2'd0) && !rx_ok;
      rd_ok   = cpu_rd && (rx_pkts != 2'd0) && rx_ok;
      rx_full = (rx_pkts >= slots);
      push_ok = rx_push && !rx_full && (rx_used != CNT_W'(DEPTH));
      end_ok  = rx_end && !rx_full;
   end

   epf_width_gate u_tx_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (commit_ok || flush_i),
      .go    (wr_ok),
      .sz    (cpu_sz),
      .ok    (tx_ok)
   );

   epf_width_gate u_rx_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_rel || flush_i),
      .go    (rd_ok),
      .sz    (cpu_sz),
      .ok    (rx_ok)
   );

   epf_pktq #(.DEPTH(DEPTH), .WR_LANES(4), .RD_LANES(1)) u_txq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush_i),
      .wr_n     (wr_ok ? nb : 3'd0),
      .wr_data  (cpu_wdata),
      .commit   (commit_ok),
      .rd_n     (3'd1),
      .rd_go    (tx_pop),
      .rd_data  (tx_byte),
      .used     (tx_used),
      .pkts     (tx_pkts),
      .head_len (tx_len),
      .released (tx_rel)
   );

   epf_pktq #(.DEPTH(DEPTH), .WR_LANES(1), .RD_LANES(4)) u_rxq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush_i),
      .wr_n     (push_ok ? 3'd1 : 3'd0),
      .wr_data  (rx_byte),
      .commit   (end_ok),
      .rd_n     (nb),
      .rd_go    (rd_ok),
      .rd_data  (rx_rd_data),
      .used     (rx_used),
      .pkts     (rx_pkts),
      .head_len (rx_len),
      .released (rx_rel)
   );

   assign rd_data = rd_ok ? rx_rd_data : 32'h0;
   assign tx_has  = (tx_pkts != 2'd0);
   assign rx_has  = (rx_pkts != 2'd0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         err_w <= 1'b0;
         err_o <= 1'b0;
         err_u <= 1'b0;
      end else begin
         if (flush_i)
            busy <= 1'b0;
         else if (commit_ok && (tx_after == {1'b0, slots}))
            busy <= 1'b1;
         else if (tx_rel)
            busy <= 1'b0;
         if (drop_w || rd_w)
            err_w <= 1'b1;
         if (drop_busy || drop_sp)
            err_o <= 1'b1;
         if (under)
            err_u <= 1'b1;
      end
   end

   // R6
   busy_means_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (tx_pkts == slots));

   // R10
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (tx_pkts == 2'd0 && rx_pkts == 2'd0 && !busy));

   // R9
   under_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_u) |-> ($past(cpu_rd) && $past(rx_pkts) == 2'd0));

   // R4
   short_read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok && (CNT_W'(nb) >= rx_len)) |-> rx_rel);

endmodule

// File: rtl/epf_ep_window.sv
module epf_ep_window #(
   parameter int NUM_EP     = 16,
   parameter int FIFO_BYTES = 16,
   parameter int ADDR_W     = 7,
   parameter int BASE       = 32,
   parameter int MP_W       = 11
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             cpu_addr,
   input  logic                          cpu_wr,
   input  logic                          cpu_rd,
   input  logic [1:0]                    cpu_size,
   input  logic [31:0]                   cpu_wdata,
   output logic [31:0]                   cpu_rdata,
   input  logic [NUM_EP-1:0]             tx_commit,
   output logic [NUM_EP-1:0]             tx_busy,
   input  logic [MP_W-1:0]               max_pkt,
   input  logic [NUM_EP-1:0]             flush_ev,
   input  logic [$clog2(NUM_EP)-1:0]     eng_tx_ep,
   input  logic                          eng_tx_pop,
   output logic [7:0]                    eng_tx_data,
   output logic [$clog2(FIFO_BYTES):0]   eng_tx_len,
   output logic                          eng_tx_has,
   input  logic [$clog2(NUM_EP)-1:0]     eng_rx_ep,
   input  logic                          eng_rx_push,
   input  logic [7:0]                    eng_rx_data,
   input  logic                          eng_rx_end,
   output logic [NUM_EP-1:0]             rx_full,
   output logic [NUM_EP-1:0]             rx_has,
   output logic [NUM_EP-1:0]             err_width,
   output logic [NUM_EP-1:0]             err_over,
   output logic [NUM_EP-1:0]             err_under
);

   localparam int EP_W  = $clog2(NUM_EP);
   localparam int CNT_W = $clog2(FIFO_BYTES) + 1;
   localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(BASE);
   localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(BASE + 4*NUM_EP);

   if ((1 << EP_W) != NUM_EP || NUM_EP < 2) begin : g_bad_ep
      $error("epf_ep_window: NUM_EP must be a power of two of at least 2");
   end
   if ((BASE % 4) != 0 || (BASE + 4*NUM_EP) > (1 << ADDR_W)) begin : g_bad_win
      $error("epf_ep_window: window must be word aligned and fit ADDR_W");
   end
   if (MP_W < 2 || FIFO_BYTES >= (1 << MP_W)) begin : g_bad_mp
      $error("epf_ep_window: MP_W too narrow for FIFO_BYTES");
   end

   logic              in_win, dbl;
   logic [ADDR_W-1:0] off;
   logic [EP_W-1:0]   ep_sel;
   logic [MP_W:0]     twice_mp;

   assign in_win   = ({1'b0, cpu_addr} >= WIN_LO) && ({1'b0, cpu_addr} < WIN_HI) &&
                     (cpu_addr[1:0] == 2'b00);
   assign off      = cpu_addr - ADDR_W'(BASE);
   assign ep_sel   = off[EP_W+1:2];
   assign twice_mp = {max_pkt, 1'b0};
   assign dbl      = (twice_mp <= (MP_W+1)'(FIFO_BYTES));

   logic [31:0]      rd_vec   [NUM_EP];
   logic [7:0]       txb_vec  [NUM_EP];
   logic [CNT_W-1:0] txl_vec  [NUM_EP];
   logic [NUM_EP-1:0] txh_vec;

   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      logic hit_e;
      assign hit_e = in_win && (ep_sel == EP_W'(e));

      epf_ep_slice #(.DEPTH(FIFO_BYTES), .FLUSHABLE(e != 0)) u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .dbl        (dbl),
         .cpu_wr     (cpu_wr && !cpu_rd && hit_e),
         .cpu_rd     (cpu_rd && hit_e),
         .cpu_sz     (cpu_size),
         .cpu_wdata  (cpu_wdata),
         .rd_data    (rd_vec[e]),
         .commit_req (tx_commit[e]),
         .flush_ev   (flush_ev[e]),
         .tx_pop     (eng_tx_pop && (eng_tx_ep == EP_W'(e))),
         .tx_byte    (txb_vec[e]),
         .tx_len     (txl_vec[e]),
         .tx_has     (txh_vec[e]),
         .rx_push    (eng_rx_push && (eng_rx_ep == EP_W'(e))),
         .rx_byte    (eng_rx_data),
         .rx_end     (eng_rx_end && (eng_rx_ep == EP_W'(e))),
         .rx_full    (rx_full[e]),
         .rx_has     (rx_has[e]),
         .busy       (tx_busy[e]),
         .err_w      (err_width[e]),
         .err_o      (err_over[e]),
         .err_u      (err_under[e])
      );
   end

   logic [31:0] rd_any;
   always_comb begin
      rd_any = '0;
      for (int e = 0; e < NUM_EP; e++)
         rd_any = rd_any | rd_vec[e];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cpu_rdata <= '0;
      else
         cpu_rdata <= (cpu_rd && in_win) ? rd_any : 32'h0;
   end

   assign eng_tx_data = txb_vec[eng_tx_ep];
   assign eng_tx_len  = txl_vec[eng_tx_ep];
   assign eng_tx_has  = txh_vec[eng_tx_ep];

   // R1
   miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !in_win) |=> (cpu_rdata == 32'h0));

   // R3
   idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> (cpu_rdata == 32'h0));

   // R2
   len_only_with_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_tx_has |-> (eng_tx_len == '0));

endmodule

// File: tb/tb_epf_ep_window.sv
module tb_epf_ep_window;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  cpu_addr;
   logic        cpu_wr, cpu_rd;
   logic [1:0]  cpu_size;
   logic [31:0] cpu_wdata, cpu_rdata;
   logic [15:0] tx_commit, tx_busy, flush_ev, rx_full, rx_has;
   logic [15:0] err_width, err_over, err_under;
   logic [10:0] max_pkt;
   logic [3:0]  eng_tx_ep, eng_rx_ep;
   logic        eng_tx_pop, eng_tx_has, eng_rx_push, eng_rx_end;
   logic [7:0]  eng_tx_data, eng_rx_data;
   logic [4:0]  eng_tx_len;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   epf_ep_window dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .tx_commit(tx_commit), .tx_busy(tx_busy), .max_pkt(max_pkt), .flush_ev(flush_ev),
      .eng_tx_ep(eng_tx_ep), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_tx_len(eng_tx_len), .eng_tx_has(eng_tx_has), .eng_rx_ep(eng_rx_ep),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_end(eng_rx_end),
      .rx_full(rx_full), .rx_has(rx_has), .err_width(err_width), .err_over(err_over),
      .err_under(err_under)
   );

   // {addr[6:0], hit, ep[3:0]}
   localparam logic [11:0] VEC [8] = '{
      12'h410, 12'h491, 12'hB9F, 12'h818, 12'h380, 12'hC00, 12'h440, 12'h797
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [10:0] mp);
      @(negedge clk);
      rst_n = 1'b0; max_pkt = mp;
      cpu_addr = '0; cpu_wr = 0; cpu_rd = 0; cpu_size = 0; cpu_wdata = '0;
      tx_commit = '0; flush_ev = '0; eng_tx_ep = '0; eng_rx_ep = '0;
      eng_tx_pop = 0; eng_rx_push = 0; eng_rx_end = 0; eng_rx_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cpu_write(input logic [6:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_size = sz; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_read(input logic [6:0] a, input logic [1:0] sz, output logic [31:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_size = sz; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      d = cpu_rdata;
   endtask

   task automatic commit(input int ep);
      @(negedge clk);
      tx_commit[ep] = 1'b1;
      @(negedge clk);
      tx_commit = '0;
   endtask

   task automatic flush(input int ep);
      @(negedge clk);
      flush_ev[ep] = 1'b1;
      @(negedge clk);
      flush_ev = '0;
   endtask

   task automatic pop_byte(input logic [3:0] ep, output logic [7:0] d);
      @(negedge clk);
      eng_tx_ep = ep;
      #1;
      d = eng_tx_data;
      eng_tx_pop = 1'b1;
      @(negedge clk);
      eng_tx_pop = 1'b0;
   endtask

   task automatic peek(input logic [3:0] ep);
      @(negedge clk);
      eng_tx_ep = ep;
      #1;
   endtask

   task automatic rx_packet(input logic [3:0] ep, input int n, input logic [7:0] first);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         eng_rx_ep = ep; eng_rx_push = 1'b1; eng_rx_data = first + 8'(i);
      end
      @(negedge clk);
      eng_rx_ep = ep; eng_rx_push = 1'b0; eng_rx_end = 1'b1;
      @(negedge clk);
      eng_rx_end = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  b;

      // R11 reset state
      do_reset(11'd8);
      check("R11 tx_busy", 32'(tx_busy), 32'h0);
      check("R11 rx_has", 32'(rx_has), 32'h0);
      check("R11 rx_full", 32'(rx_full), 32'h0);
      check("R11 errors", 32'(err_width | err_over | err_under), 32'h0);
      check("R11 rdata", cpu_rdata, 32'h0);

      // R1 decode table, double buffering
      for (int i = 0; i < 8; i++) begin
         logic [11:0] v;
         v = VEC[i];
         if (v[4]) begin
            cpu_write(v[11:5], 2'd0, 32'h30 + 32'(i));
            commit(int'(v[3:0]));
            peek(v[3:0]);
            check("R1 hit present", 32'(eng_tx_has), 32'h1);
            pop_byte(v[3:0], b);
            check("R1 hit data", 32'(b), 32'h30 + 32'(i));
         end else begin
            cpu_write(v[11:5], 2'd2, 32'hDEADBEEF);
            cpu_read(v[11:5], 2'd2, d);
            check("R1 miss read", d, 32'h0);
         end
      end
      check("R1 miss stores left no flag", 32'(err_width | err_over | tx_busy), 32'h0);

      // R2 word then short final halfword on ep2
      cpu_write(7'h28, 2'd2, 32'h44332211);
      cpu_write(7'h28, 2'd1, 32'h00006655);
      commit(2);
      peek(4'd2);
      check("R2 head length", 32'(eng_tx_len), 32'd6);
      for (int i = 0; i < 6; i++) begin
         pop_byte(4'd2, b);
         check("R2 byte order", 32'(b), 32'h11 * 32'(i + 1));
      end
      check("R5 short final legal", 32'(err_width[2]), 32'h0);

      // R6 double buffering on ep4
      cpu_write(7'h30, 2'd0, 32'h41);
      commit(4);
      check("R6 one of two slots", 32'(tx_busy[4]), 32'h0);
      cpu_write(7'h30, 2'd0, 32'h42);
      commit(4);
      check("R6 both slots full", 32'(tx_busy[4]), 32'h1);
      pop_byte(4'd4, b);
      check("R6 first packet", 32'(b), 32'h41);
      check("R6 busy falls on drain", 32'(tx_busy[4]), 32'h0);

      // R5 width violation on ep6
      cpu_write(7'h38, 2'd2, 32'h04030201);
      cpu_write(7'h38, 2'd0, 32'h05);
      check("R5 narrower final ok", 32'(err_width[6]), 32'h0);
      cpu_write(7'h38, 2'd0, 32'h06);
      check("R5 access after close", 32'(err_width[6]), 32'h1);
      commit(6);
      peek(4'd6);
      check("R5 discarded byte", 32'(eng_tx_len), 32'd5);

      // R3 / R4 / R9 receive on ep7
      rx_packet(4'd7, 5, 8'h01);
      check("R3 packet readable", 32'(rx_has[7]), 32'h1);
      cpu_read(7'h3C, 2'd2, d);
      check("R3 word read", d, 32'h04030201);
      cpu_read(7'h3C, 2'd2, d);
      check("R4 short final read", d, 32'h00000005);
      check("R4 packet released", 32'(rx_has[7]), 32'h0);
      cpu_read(7'h3C, 2'd2, d);
      check("R9 empty read data", d, 32'h0);
      check("R9 underrun flag", 32'(err_under[7]), 32'h1);

      // R5 read side on ep10
      rx_packet(4'd10, 6, 8'h11);
      cpu_read(7'h48, 2'd1, d);
      check("R5 half read", d, 32'h00001211);
      cpu_read(7'h48, 2'd2, d);
      check("R5 wider read data", d, 32'h0);
      check("R5 wider read flag", 32'(err_width[10]), 32'h1);
      cpu_read(7'h48, 2'd1, d);
      check("R5 nothing removed", d, 32'h00001413);
      cpu_read(7'h48, 2'd1, d);
      check("R5 last half", d, 32'h00001615);

      // R10 flush: ep9 empties, ep0 keeps data
      cpu_write(7'h44, 2'd0, 32'h99);
      commit(9);
      rx_packet(4'd9, 1, 8'h77);
      cpu_write(7'h20, 2'd0, 32'h5A);
      commit(0);
      flush(9);
      flush(0);
      peek(4'd9);
      check("R10 tx flushed", 32'(eng_tx_has), 32'h0);
      check("R10 rx flushed", 32'(rx_has[9]), 32'h0);
      peek(4'd0);
      check("R10 ep0 immune", 32'(eng_tx_has), 32'h1);
      check("R10 ep0 data", 32'(eng_tx_data), 32'h5A);

      // R8 / R6 single buffering on ep5
      do_reset(11'd16);
      for (int i = 0; i < 4; i++)
         cpu_write(7'h34, 2'd2, 32'h01010101 * 32'(i + 1));
      check("R8 exact fill", 32'(err_over[5]), 32'h0);
      cpu_write(7'h34, 2'd0, 32'hEE);
      check("R8 overrun flag", 32'(err_over[5]), 32'h1);
      commit(5);
      peek(4'd5);
      check("R8 length kept", 32'(eng_tx_len), 32'd16);
      check("R6 single busy", 32'(tx_busy[5]), 32'h1);

      // R7 store while busy on ep3
      cpu_write(7'h2C, 2'd0, 32'hAB);
      commit(3);
      cpu_write(7'h2C, 2'd0, 32'hCD);
      check("R7 overrun flag", 32'(err_over[3]), 32'h1);
      pop_byte(4'd3, b);
      check("R7 first byte", 32'(b), 32'hAB);
      check("R7 busy cleared", 32'(tx_busy[3]), 32'h0);
      peek(4'd3);
      check("R7 dropped byte absent", 32'(eng_tx_has), 32'h0);

      // R12 single slot on ep8
      rx_packet(4'd8, 2, 8'hA1);
      check("R12 full flag", 32'(rx_full[8]), 32'h1);
      rx_packet(4'd8, 1, 8'hB1);
      cpu_read(7'h40, 2'd2, d);
      check("R12 first packet", d, 32'h0000A2A1);
      check("R12 second dropped", 32'(rx_has[8]), 32'h0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule